// File: doc/BRIEF.md
# Multi-Lane Video Stream Event Classifier

This block sits behind the symbol decoder of a one-, two- or four-lane video link. On each clock, every lane presents one decoded byte, a control/data flag and a valid bit. The block gives each symbol time ("state") an 8-bit event code one clock later. Bits 7:6 give the region. Bits 5:2 give the packet or slot type. Bit 1 is a consistency error and bit 0 is a cross-lane mismatch error. A capture or trigger stage downstream can store, filter or trigger on the codes without decoding the link protocol again.

The classifier follows the blanking sequence. A blanking-start or scrambler-reset symbol is followed by three field slots: the blanking-ID byte, the video time-stamp byte and the audio time-stamp byte. Dummy fill comes next, along with any secondary packets. A blanking-end symbol then opens active video. Lane 0 decides the classification. The other active lanes are compared against lane 0 on control states and field slots. Each lane also counts blanking-end symbols to catch lost scrambler resets. The number of active lanes is taken from a static input while reset is held.

Top module: `vlc_top`

## Requirements
- R1: A state is a clock with `sym_vld[0]` high. Its code appears on `evt_code` with `evt_vld` high exactly one clock later. A clock without a state gives `evt_vld` low, and `evt_code` keeps its last value.
- R2: Region bits 7:6 are 00 in horizontal blanking, 01 in vertical blanking and {1, field} in active video. The blanking-ID byte sets the region in its own state: bit 0 set means vertical, clear means horizontal. Its bit 1 is latched as the field.
- R3: Control byte 0xBC (blanking start) is coded with subtype 1010, and control byte 0x1C (scrambler reset) with subtype 0101. Both keep the region that was current before them. The next three states are coded 0010 (blanking ID), 0011 (video stamp) and 0100 (audio stamp). They are taken from lane 0 whatever their flag.
- R4: Control byte 0xFB (blanking end) is coded 0001 in the current region, and every later state is in the active region. In active video, any symbol other than 0xBC, 0x1C or 0xFB is a pixel, coded 0001. Outside active video and packets, an unrecognised state is dummy fill, coded 0110.
- R5: In blanking, control byte 0x5C opens an audio packet (1000). Control byte 0xF7 opens an attribute packet (0111), but only in vertical blanking. In horizontal blanking 0xF7 is dummy fill. The packet code is held through the state that carries control byte 0xFD, whatever the packet contains.
- R6: Bit 0 is set when at least one active lane has its flag and valid bit high, or the state is one of the three field slots, and the {valid, flag, byte} of some active lane differs from that of lane 0.
- R7: Bit 1 is set on the video-stamp slot when blanking-ID bit 3 is 1 and the video stamp is nonzero. It is also set on the audio-stamp slot when blanking-ID bit 4 is 1 and the audio stamp is nonzero.
- R8: Each lane counts the 0xFB control symbols it carries, and a 0x1C control symbol on that lane clears its count. The 512th blanking end with no reset in between sets bit 1 on that state. The count then saturates and does not raise the flag again until it is cleared.
- R9: `lane_mode` is sampled only while `rst_n` is low: 0 selects lane 0, 1 selects lanes 0–1, and 2 or 3 selects all four. Lanes outside the selection affect no code bit, and changing `lane_mode` after reset has no effect.
- R10: An error flag applies only to the state that caused it. The next clean state shows both error bits clear.
- R11: While in reset and right after it, `evt_vld` is 0 and `evt_code` is 0x00. The classifier starts in vertical blanking, field 0, outside any packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_mode | input | 2 | Active lane selection, sampled during reset |
| sym_vld | input | 4 | Per-lane symbol valid; lane 0 marks a state |
| sym_ctl | input | 4 | Per-lane control flag (1 = control symbol) |
| sym_byte | input | 32 | Per-lane decoded byte, lane i at bits 8i+7:8i |
| evt_vld | output | 1 | Event code valid |
| evt_code | output | 8 | Region, subtype and error bits of the previous state |

## Verification
A wrong slot phase shows up on the very next state: a field slot is coded as fill, or a fill byte as a slot, and the error bits then land on the wrong states. A wrong region or field latch is visible at the first blanking end that follows, because the pixel code carries the field. A wrong lane mask or comparison shows as a mismatch bit that appears or goes missing on the state that exposes it. An off-by-one in the per-lane counter moves the missed-reset flag by one state, and only the 512-state run can show it. The bench therefore runs exactly that count, plus one extra state to prove saturation.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam logic [7:0] SYM_BS = 8'hBC;
  localparam logic [7:0] SYM_SR = 8'h1C;
  localparam logic [7:0] SYM_BE = 8'hFB;
  localparam logic [7:0] SYM_SS = 8'h5C;
  localparam logic [7:0] SYM_SA = 8'hF7;
  localparam logic [7:0] SYM_SE = 8'hFD;

  localparam logic [3:0] ST_PIXEL = 4'h1;
  localparam logic [3:0] ST_BE    = 4'h1;
  localparam logic [3:0] ST_VBID  = 4'h2;
  localparam logic [3:0] ST_MVID  = 4'h3;
  localparam logic [3:0] ST_MAUD  = 4'h4;
  localparam logic [3:0] ST_SR    = 4'h5;
  localparam logic [3:0] ST_DUMMY = 4'h6;
  localparam logic [3:0] ST_ATTR  = 4'h7;
  localparam logic [3:0] ST_AUDIO = 4'h8;
  localparam logic [3:0] ST_BS    = 4'hA;

  typedef enum logic [1:0] {RG_HB, RG_VB, RG_ACT} region_t;
  typedef enum logic [2:0] {PH_FREE, PH_VBID, PH_MVID, PH_MAUD, PH_PKT} phase_t;

  function automatic logic [1:0] region_bits(region_t r, logic fld);
    case (r)
      RG_HB:   return 2'b00;
      RG_VB:   return 2'b01;
      default: return {1'b1, fld};
    endcase
  endfunction

  function automatic int lane_count(logic [1:0] mode);
    case (mode)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic field_err(logic flag, logic [7:0] value);
    return flag && (value != 8'h00);
  endfunction
endpackage

// File: rtl/vlc_lane_cmp.sv
module vlc_lane_cmp #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0]   act,
  input  logic [NUM_LANES-1:0]   vld,
  input  logic [NUM_LANES-1:0]   ctl,
  input  logic [NUM_LANES*8-1:0] data,
  input  logic                   field_slot,
  output logic                   mism
);
  logic [NUM_LANES-1:0] diff;
  logic [NUM_LANES-1:0] ctl_seen;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign diff[i]     = act[i] && ({vld[i], ctl[i], data[i*8 +: 8]} != {vld[0], ctl[0], data[7:0]});
    assign ctl_seen[i] = act[i] && vld[i] && ctl[i];
  end

  assign mism = ((|ctl_seen) || field_slot) && (|diff);
endmodule

// File: rtl/vlc_sr_watch.sv
module vlc_sr_watch #(
  parameter int NUM_LANES = 4,
  parameter int BE_LIMIT  = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe,
  input  logic [NUM_LANES-1:0]   act,
  input  logic [NUM_LANES-1:0]   vld,
  input  logic [NUM_LANES-1:0]   ctl,
  input  logic [NUM_LANES*8-1:0] data,
  output logic                   missed
);
  import vlc_pkg::*;
  localparam int CW = $clog2(BE_LIMIT + 1);
  localparam logic [CW-1:0] LIM  = CW'(BE_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(BE_LIMIT - 1);

  logic [NUM_LANES-1:0] fire;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    logic is_sr, is_be, take;
    assign take  = strobe && vld[i];
    assign is_sr = ctl[i] && (data[i*8 +: 8] == SYM_SR);
    assign is_be = ctl[i] && (data[i*8 +: 8] == SYM_BE);
    assign fire[i] = take && act[i] && is_be && (cnt_q == LAST);

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (take) begin
        if (is_sr) cnt_q <= '0;
        else if (is_be && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
      end
    end

    // R8: counter never passes its saturation value
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LIM);
    // R8: a lane signals once and then stays quiet until cleared
    a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n) fire[i] |=> !fire[i]);
  end

  assign missed = |fire;
endmodule

// File: rtl/vlc_region_fsm.sv
module vlc_region_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       ctl0,
  input  logic [7:0] byte0,
  output logic       field_slot,
  output logic [5:0] code_hi,
  output logic       chk_err
);
  import vlc_pkg::*;

  region_t    rg_q, rg_n;
  phase_t     ph_q, ph_n;
  logic       fld_q, fld_n, nv_q, nv_n, mute_q, mute_n;
  logic [3:0] pkt_q, pkt_n, sub;
  logic [1:0] rb;

  always_comb begin
    rg_n = rg_q; ph_n = ph_q; fld_n = fld_q; nv_n = nv_q; mute_n = mute_q; pkt_n = pkt_q;
    sub = ST_DUMMY;
    rb = region_bits(rg_q, fld_q);
    chk_err = 1'b0;
    if (ph_q == PH_PKT) begin
      sub = pkt_q;
      if (ctl0 && byte0 == SYM_SE) ph_n = PH_FREE;
    end else if (ph_q == PH_VBID) begin
      rg_n = byte0[0] ? RG_VB : RG_HB;
      fld_n = byte0[1]; nv_n = byte0[3]; mute_n = byte0[4];
      rb = region_bits(rg_n, fld_n);
      sub = ST_VBID; ph_n = PH_MVID;
    end else if (ph_q == PH_MVID) begin
      sub = ST_MVID; chk_err = field_err(nv_q, byte0); ph_n = PH_MAUD;
    end else if (ph_q == PH_MAUD) begin
      sub = ST_MAUD; chk_err = field_err(mute_q, byte0); ph_n = PH_FREE;
    end else if (ctl0 && (byte0 == SYM_BS || byte0 == SYM_SR)) begin
      sub = (byte0 == SYM_SR) ? ST_SR : ST_BS; ph_n = PH_VBID;
    end else if (ctl0 && byte0 == SYM_BE) begin
      sub = ST_BE; rg_n = RG_ACT;
    end else if (rg_q == RG_ACT) begin
      sub = ST_PIXEL;
    end else if (ctl0 && byte0 == SYM_SS) begin
      sub = ST_AUDIO; pkt_n = ST_AUDIO; ph_n = PH_PKT;
    end else if (ctl0 && byte0 == SYM_SA && rg_q == RG_VB) begin
      sub = ST_ATTR; pkt_n = ST_ATTR; ph_n = PH_PKT;
    end
    code_hi = {rb, sub};
  end

  assign field_slot = (ph_q == PH_VBID) || (ph_q == PH_MVID) || (ph_q == PH_MAUD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_q <= RG_VB; ph_q <= PH_FREE; fld_q <= 1'b0;
      nv_q <= 1'b0; mute_q <= 1'b0; pkt_q <= ST_DUMMY;
    end else if (strobe) begin
      rg_q <= rg_n; ph_q <= ph_n; fld_q <= fld_n;
      nv_q <= nv_n; mute_q <= mute_n; pkt_q <= pkt_n;
    end
  end

  // R3: a field slot can only follow another slot or a blanking start/reset
  a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ph_q == PH_MVID) |-> $past(ph_q) == PH_VBID || $past(ph_q) == PH_MVID);
endmodule

// File: rtl/vlc_top.sv
module vlc_top #(
  parameter int NUM_LANES = 4,
  parameter int BE_LIMIT  = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             lane_mode,
  input  logic [NUM_LANES-1:0]   sym_vld,
  input  logic [NUM_LANES-1:0]   sym_ctl,
  input  logic [NUM_LANES*8-1:0] sym_byte,
  output logic                   evt_vld,
  output logic [7:0]             evt_code
);
  import vlc_pkg::*;

  logic [NUM_LANES-1:0] act_q, act_d;
  logic       strobe, field_slot, mism, missed, chk_err;
  logic [5:0] code_hi;

  assign strobe = sym_vld[0];

  always_comb
    for (int i = 0; i < NUM_LANES; i++) act_d[i] = (i < lane_count(lane_mode));

  always_ff @(posedge clk)
    if (!rst_n) act_q <= act_d;

  vlc_region_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ctl0(sym_ctl[0]), .byte0(sym_byte[7:0]),
    .field_slot(field_slot), .code_hi(code_hi), .chk_err(chk_err)
  );

  vlc_lane_cmp #(.NUM_LANES(NUM_LANES)) u_cmp (
    .act(act_q), .vld(sym_vld), .ctl(sym_ctl), .data(sym_byte),
    .field_slot(field_slot), .mism(mism)
  );

  vlc_sr_watch #(.NUM_LANES(NUM_LANES), .BE_LIMIT(BE_LIMIT)) u_srw (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .act(act_q), .vld(sym_vld),
    .ctl(sym_ctl), .data(sym_byte), .missed(missed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_vld <= 1'b0; evt_code <= 8'h00;
    end else begin
      evt_vld <= strobe;
      if (strobe) evt_code <= {code_hi, chk_err || missed, mism};
    end
  end

  // R1: every state yields a code on the following clock
  a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld[0] |=> evt_vld);
  // R1: the code holds while no state arrives
  a_r1_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_vld |-> $stable(evt_code));
  // R4: the active region is only entered right after a blanking end
  a_r4_active_after_be: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_code[7]) |-> $past(evt_code[5:2]) == ST_BE);
  // R3: a video-stamp code in blanking always follows a blanking-ID code
  a_r3_mvid_after_vbid: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_code[7] && evt_code[5:2] == ST_MVID) |-> $past(evt_code[5:2]) == ST_VBID);
endmodule

// File: tb/vlc_top_tb.sv
module vlc_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_mode = 2'd2;
  logic [3:0]  sym_vld = '0;
  logic [3:0]  sym_ctl = '0;
  logic [31:0] sym_byte = '0;
  logic        evt_vld;
  logic [7:0]  evt_code;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlc_top u_dut (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .sym_vld(sym_vld),
    .sym_ctl(sym_ctl), .sym_byte(sym_byte), .evt_vld(evt_vld), .evt_code(evt_code)
  );

  task automatic check(input string rq, input logic [7:0] got, input logic [7:0] expv);
    n_vec++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", rq, got, expv);
    end
  endtask

  // monitor: pops the reference queue as codes come out
  always @(negedge clk) begin
    if (rst_n && !done && evt_vld) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R1: unexpected code 0x%02h expected none", evt_code);
      end else begin
        check(req_q.pop_front(), evt_code, exp_q.pop_front());
      end
    end
  end

  task automatic put(input logic [3:0] v, input logic [3:0] k, input logic [31:0] d,
                     input logic [7:0] expv, input string rq);
    @(negedge clk);
    sym_vld = v; sym_ctl = k; sym_byte = d;
    if (v[0]) begin exp_q.push_back(expv); req_q.push_back(rq); end
  endtask

  task automatic all4(input logic k, input logic [7:0] d, input logic [7:0] expv, input string rq);
    put(4'hF, {4{k}}, {4{d}}, expv, rq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(4'h0, 4'h0, 32'h0, 8'h00, "");
  endtask

  task automatic do_reset(input logic [1:0] mode);
    idle(3);
    rst_n = 1'b0; lane_mode = mode;
    repeat (3) @(negedge clk);
    check("R11 reset vld", {7'b0, evt_vld}, 8'h00);
    check("R11 reset code", evt_code, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 post-reset vld", {7'b0, evt_vld}, 8'h00);
  endtask

  initial begin
    do_reset(2'd2);
    // R3 blanking start from reset region (vertical), then slots
    all4(1, 8'hBC, 8'h68, "R3 BS");
    all4(0, 8'h01, 8'h48, "R2 VBID vertical");
    all4(0, 8'h00, 8'h4C, "R3 Mvid");
    all4(0, 8'h00, 8'h50, "R3 Maud");
    all4(0, 8'h55, 8'h58, "R4 dummy");
    // R5 attribute packet held, inner control ignored
    all4(1, 8'hF7, 8'h5C, "R5 attr start");
    all4(0, 8'h12, 8'h5C, "R5 attr body");
    all4(1, 8'hFB, 8'h5C, "R5 attr holds over BE");
    all4(1, 8'hFD, 8'h5C, "R5 attr end");
    all4(0, 8'h00, 8'h58, "R5 after packet");
    all4(1, 8'hFB, 8'h44, "R4 BE vertical");
    all4(0, 8'h33, 8'h84, "R4 pixel f0");
    idle(2);
    check("R1 gap vld", {7'b0, evt_vld}, 8'h00);
    check("R1 gap hold", evt_code, 8'h84);
    all4(1, 8'hBC, 8'hA8, "R3 BS from active");
    all4(0, 8'h02, 8'h08, "R2 VBID horiz f1");
    all4(0, 8'h00, 8'h0C, "R3 Mvid");
    all4(0, 8'h00, 8'h10, "R3 Maud");
    all4(1, 8'h5C, 8'h20, "R5 audio start");
    all4(0, 8'h77, 8'h20, "R5 audio body");
    all4(1, 8'hFD, 8'h20, "R5 audio end");
    all4(0, 8'h00, 8'h18, "R4 dummy horiz");
    all4(1, 8'hF7, 8'h18, "R5 attr start ignored in horiz");
    all4(1, 8'hFB, 8'h04, "R4 BE horiz");
    all4(0, 8'h33, 8'hC4, "R2 pixel f1");
    // R7 field checks
    all4(1, 8'h1C, 8'hD4, "R3 SR from active f1");
    all4(0, 8'h18, 8'h08, "R2 VBID flags");
    all4(0, 8'h05, 8'h0E, "R7 video check");
    all4(0, 8'h03, 8'h12, "R7 audio check");
    all4(0, 8'h00, 8'h18, "R10 flag cleared");
    all4(1, 8'hFB, 8'h04, "R4 BE");
    all4(0, 8'h00, 8'h84, "R2 pixel f0");
    all4(1, 8'hBC, 8'hA8, "R3 BS");
    all4(0, 8'h08, 8'h08, "R2 VBID no-video");
    all4(0, 8'h00, 8'h0C, "R7 zero stamp no error");
    all4(0, 8'h09, 8'h10, "R7 mute clear no error");
    // R6 mismatch
    put(4'hF, 4'b0100, 32'h11BC1111, 8'h19, "R6 control on one lane");
    put(4'hF, 4'b0000, 32'h04030201, 8'h18, "R6 data differs no control");
    put(4'b0111, 4'hF, {4{8'hFB}}, 8'h05, "R6 lane3 valid low on BE");
    all4(0, 8'h00, 8'h84, "R10 pixel clean");
    // R8 missed reset
    all4(1, 8'h1C, 8'h94, "R3 SR from active f0");
    all4(0, 8'h00, 8'h08, "R2 VBID");
    all4(0, 8'h00, 8'h0C, "R3 Mvid");
    all4(0, 8'h00, 8'h10, "R3 Maud");
    all4(1, 8'hFB, 8'h04, "R8 BE 1");
    for (int i = 2; i <= 511; i++) all4(1, 8'hFB, 8'h84, "R8 BE run");
    all4(1, 8'hFB, 8'h86, "R8 BE 512 missed");
    all4(1, 8'hFB, 8'h84, "R8 saturated no refire");
    all4(1, 8'h1C, 8'h94, "R8 SR clears");
    all4(0, 8'h00, 8'h08, "R2 VBID");
    all4(0, 8'h00, 8'h0C, "R3 Mvid");
    all4(0, 8'h00, 8'h10, "R3 Maud");
    all4(1, 8'hFB, 8'h04, "R8 count restarted");
    // R9 single lane: others garbage
    do_reset(2'd0);
    put(4'b0001, 4'b1111, 32'h1C1C1CBC, 8'h68, "R9 one lane BS");
    put(4'b1111, 4'b0001, 32'hAAAAAA01, 8'h48, "R9 one lane VBID");
    put(4'b0011, 4'b0000, 32'h00004000, 8'h4C, "R9 one lane Mvid");
    put(4'b0001, 4'b0000, 32'h00000000, 8'h50, "R9 one lane Maud");
    // R9 two lanes
    do_reset(2'd1);
    put(4'b0011, 4'b1011, 32'h1C00BCBC, 8'h68, "R9 two lanes BS");
    put(4'b0111, 4'b0000, 32'h00AA0101, 8'h48, "R9 two lanes VBID");
    put(4'b0011, 4'b0000, 32'h00004000, 8'h4D, "R6 lane1 differs");
    put(4'b0111, 4'b0000, 32'h00770000, 8'h50, "R9 lane2 ignored");
    lane_mode = 2'd2;
    put(4'b1111, 4'b0100, 32'h00BC0000, 8'h58, "R9 mode change after reset ignored");
    idle(3);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R1: %0d codes missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule